// File: doc/BRIEF.md
# LCD Drive Power Sequencer

This block controls the order in which an LCD bias generator and its display output are powered up and down. Software programs a method register, which picks the internal boost path or the capacitor-split path. It also programs a contrast register and a control register. The block checks the slice/bias code against the chosen method. Slow tick pulses time the contrast settling and generator settling intervals. Only after these checks and waits does the block assert the generator run, blank and display outputs, strictly in that order.

Power-down runs in reverse order. The generator enable cannot be cleared while the blank or display output is still requested. A status register reports the sequencer state and a sticky flag that catches a premature display request. The analog circuits, waveform generation, display memory and pin muxing are outside the block. The block drives only the run/blank/display enables, the slice/bias code and the effective display-area select.

Top module: `lcd_pwr_seq`

## Requirements
- R1: Register map: address 0 is the method register (bits 1:0: 01 = boost, 10 = split), address 1 is the control register, address 2 is the 5-bit contrast register, and address 3 is the status register. Status bits 2:0 hold the state code: 0 idle, 1 reference settling, 2 generator settling/ready, 3 blank, 4 displaying, 5 sequence error. Status bit 3 is the sticky flag. After reset every register reads 0 and every output is low.
- R2: Control bits 2:0 hold the slice/bias code. Codes 3 and 4 are 1/3 bias, code 5 is 8-slice 1/4 bias, and every other code is a different bias. When generator enable (control bit 5) is set from idle, boost accepts codes 3, 4 and 5, and split accepts codes 3 and 4. Any other code, or any other method value, puts the block in state 5 with `gen_on` low.
- R3: With boost, the generator stays off (state 1) until REF_TICKS tick pulses have been counted since the last contrast write. With split, no such wait applies.
- R4: After the generator starts, the blank request (control bit 6) is honoured only after a further BOOST_TICKS (boost) or SPLIT_TICKS (split) tick pulses.
- R5: In state 3, `blank_out` is high and `disp_out` is low. Clearing control bit 6 returns the block to state 2.
- R6: A display request (control bit 7) is honoured only from state 3 or 4. A write that sets bit 7 in any other state stores 0 in bit 7 and sets status bit 3. Writing 1 to status bit 3 clears the flag.
- R7: While the slice/bias code is 5 (8-slice), `area_sel` is 0 whatever control bits 4:3 hold. Otherwise `area_sel` follows control bits 4:3.
- R8: While the generator runs and control bit 6 or 7 is still stored as 1, a write that clears bit 5 leaves bit 5 at 1 and the generator on. Once both are 0, clearing bit 5 returns the block to idle with `gen_on` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timing pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| gen_on | output | 1 | Bias generator run enable |
| blank_out | output | 1 | Drive non-selected waveforms on all pins |
| disp_out | output | 1 | Drive display data waveforms |
| area_sel | output | 2 | Effective display-area select |
| slice_bias | output | 3 | Slice/bias code |

## Verification
A register write lands at the clock edge that samples it, and the state moves on the following edge. The outputs therefore reflect a write two edges after the write strobe is first driven. The bench always waits one extra edge after each write and samples at the falling edge. A tick pulse advances a counter at its own edge, and the state change that completes a wait appears one edge later. Waits are therefore checked one tick short of the limit, where the state must not have changed, and again at the limit plus one edge.

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int REF_TICKS   = 2000,
  parameter int BOOST_TICKS = 500,
  parameter int SPLIT_TICKS = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       gen_on,
  output logic       blank_out,
  output logic       disp_out,
  output logic [1:0] area_sel,
  output logic [2:0] slice_bias
);
  localparam int RW   = $clog2(REF_TICKS + 1);
  localparam int SMAX = (BOOST_TICKS > SPLIT_TICKS) ? BOOST_TICKS : SPLIT_TICKS;
  localparam int SW   = $clog2(SMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_REF = 3'd1, S_GEN = 3'd2,
    S_BLANK = 3'd3, S_DISP = 3'd4, S_ERR = 3'd5
  } st_t;

  st_t           state, nxt;
  logic [1:0]    method;
  logic [7:0]    ctrl;
  logic [4:0]    vref;
  logic          sticky;
  logic [RW-1:0] ref_cnt;
  logic [SW-1:0] set_cnt;

  wire       boost   = (method == 2'b01);
  wire       split   = (method == 2'b10);
  wire [2:0] code    = ctrl[2:0];
  wire       bias_ok = boost ? (code >= 3'd3 && code <= 3'd5)
                     : split ? (code == 3'd3 || code == 3'd4) : 1'b0;
  wire       ref_ok  = (ref_cnt == RW'(REF_TICKS));
  wire [SW-1:0] limit = boost ? SW'(BOOST_TICKS) : SW'(SPLIT_TICKS);
  wire       settled = (set_cnt >= limit);
  wire       running = (state == S_GEN) || (state == S_BLANK) || (state == S_DISP);
  wire       shown   = (state == S_BLANK) || (state == S_DISP);
  wire       wr_ctrl = wr_en && (wr_addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      method <= 2'b00;
      ctrl   <= 8'h00;
      vref   <= 5'd0;
      sticky <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: method <= wr_data[1:0];
        2'd1: begin
          ctrl[4:0] <= wr_data[4:0];
          ctrl[6]   <= wr_data[6];
          ctrl[5]   <= wr_data[5] | (ctrl[5] & running & (ctrl[6] | ctrl[7]));
          if (wr_data[7] && !shown) begin
            ctrl[7] <= 1'b0;
            sticky  <= 1'b1;
          end else begin
            ctrl[7] <= wr_data[7];
          end
        end
        2'd2: vref <= wr_data[4:0];
        default: if (wr_data[3]) sticky <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ref_cnt <= '0;
    else if (wr_en && wr_addr == 2'd2) ref_cnt <= '0;
    else if (tick && !ref_ok)          ref_cnt <= ref_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                set_cnt <= '0;
    else if (!running)         set_cnt <= '0;
    else if (tick && !settled) set_cnt <= set_cnt + 1'b1;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:
        if (ctrl[5]) begin
          if (!bias_ok)              nxt = S_ERR;
          else if (boost && !ref_ok) nxt = S_REF;
          else                       nxt = S_GEN;
        end
      S_REF:
        if (!ctrl[5])      nxt = S_IDLE;
        else if (!bias_ok) nxt = S_ERR;
        else if (ref_ok)   nxt = S_GEN;
      S_GEN:
        if (!ctrl[5])                nxt = S_IDLE;
        else if (settled && ctrl[6]) nxt = S_BLANK;
      S_BLANK:
        if (!ctrl[6])     nxt = S_GEN;
        else if (ctrl[7]) nxt = S_DISP;
      S_DISP:
        if (!ctrl[6])      nxt = S_GEN;
        else if (!ctrl[7]) nxt = S_BLANK;
      default:
        if (!ctrl[5]) nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign gen_on     = running;
  assign blank_out  = (state == S_BLANK);
  assign disp_out   = (state == S_DISP);
  assign slice_bias = code;
  assign area_sel   = (code == 3'd5) ? 2'b00 : ctrl[4:3];

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {6'b0, method};
      2'd1:    rd_data = ctrl;
      2'd2:    rd_data = {3'b0, vref};
      default: rd_data = {4'b0, sticky, state};
    endcase
  end
endmodule

module lcd_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gen_on,
  input logic       blank_out,
  input logic       disp_out,
  input logic [1:0] area_sel,
  input logic [2:0] slice_bias,
  input logic       boost,
  input logic       ref_ok,
  input logic       settled
);
  assert_ref_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gen_on) && $past(boost)) |-> $past(ref_ok));
  assert_settle_before_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blank_out) && $past(gen_on)) |-> $past(settled));
  assert_blank_needs_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_out || disp_out) |-> gen_on);
  assert_disp_after_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_out) |-> $past(blank_out));
  assert_area_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_bias == 3'd5) |-> (area_sel == 2'd0));
  assert_shutdown_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_on) |-> $past(!blank_out && !disp_out));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .blank_out(blank_out),
  .disp_out(disp_out), .area_sel(area_sel), .slice_bias(slice_bias),
  .boost(boost), .ref_ok(ref_ok), .settled(settled)
);

// File: tb/sim_lcd_pwr_seq.sv
`timescale 1ns/1ps
module sim_lcd_pwr_seq;
  localparam int RT = 4, BT = 3, ST = 2;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic gen_on, blank_out, disp_out;
  logic [1:0] area_sel;
  logic [2:0] slice_bias;
  int errors = 0, checks = 0;

  lcd_pwr_seq #(.REF_TICKS(RT), .BOOST_TICKS(BT), .SPLIT_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .gen_on(gen_on),
    .blank_out(blank_out), .disp_out(disp_out), .area_sel(area_sel),
    .slice_bias(slice_bias));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic chk_state(input string req, input int exp);
    logic [7:0] v;
    rd(2'd3, v);
    chk(req, v[2:0], exp);
  endtask

  initial begin
    logic [7:0] v;
    #20 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 reset outputs", {gen_on, blank_out, disp_out, area_sel, slice_bias}, 0);

    // R2 exhaustive method x code sweep (reference already settled)
    wr(2'd2, 8'h10);
    ticks(RT);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        bit ok;
        ok = (m == 1) ? (c >= 3 && c <= 5) : (m == 2) ? (c == 3 || c == 4) : 1'b0;
        wr(2'd0, 8'(m));
        wr(2'd1, 8'h20 | 8'(c));
        step();
        chk_state("R2 bias check state", ok ? 2 : 5);
        chk("R2 bias check gen_on", gen_on, ok);
        wr(2'd1, 8'h00);
        step();
      end
    end
    chk_state("R2 back to idle", 0);

    // R3 boost reference wait
    wr(2'd2, 8'h0C);
    ticks(RT - 1);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h23);
    step();
    chk_state("R3 ref settling", 1);
    chk("R3 gen off while settling", gen_on, 0);
    ticks(1);
    step();
    chk_state("R3 gen after ref wait", 2);
    chk("R3 gen on", gen_on, 1);

    // R4 boost settle, R6 early display
    wr(2'd1, 8'h63);
    ticks(BT - 1);
    step();
    chk_state("R4 blank held before settle", 2);
    chk("R4 blank_out low", blank_out, 0);
    wr(2'd1, 8'hE3);
    rd(2'd1, v);
    chk("R6 early disp bit reads 0", v, 8'h63);
    rd(2'd3, v);
    chk("R6 sticky set", v, 8'h0A);
    wr(2'd3, 8'h08);
    rd(2'd3, v);
    chk("R6 sticky cleared", v, 8'h02);
    ticks(1);
    step();
    chk_state("R5 blank state", 3);
    chk("R5 blank outputs", {blank_out, disp_out}, 2'b10);
    wr(2'd1, 8'hE3);
    step();
    chk_state("R6 display state", 4);
    chk("R6 disp outputs", {blank_out, disp_out}, 2'b01);
    rd(2'd3, v);
    chk("R6 no sticky from blank", v[3], 0);

    // R7 area select
    wr(2'd1, 8'hFB);
    step();
    chk("R7 area follows bits", area_sel, 3);
    wr(2'd1, 8'hFD);
    step();
    chk("R7 area masked in 8-slice", area_sel, 0);
    chk("R7 slice code out", slice_bias, 5);
    chk_state("R7 still displaying", 4);

    // R8 shutdown interlock
    wr(2'd1, 8'h00);
    step();
    rd(2'd1, v);
    chk("R8 gen bit kept", v, 8'h20);
    chk("R8 gen still on", gen_on, 1);
    chk_state("R8 back to gen state", 2);
    wr(2'd1, 8'h00);
    step();
    chk("R8 gen off after clean stop", gen_on, 0);
    chk_state("R8 idle", 0);

    // R3/R4 split: no ref wait, shorter settle
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h24);
    step();
    chk_state("R3 split skips ref wait", 2);
    wr(2'd1, 8'h64);
    ticks(ST - 1);
    step();
    chk_state("R4 split settle not done", 2);
    ticks(1);
    step();
    chk_state("R4 split settle done", 3);
    wr(2'd1, 8'h24);
    step();
    chk_state("R5 blank cleared to gen", 2);
    wr(2'd1, 8'h00);
    step();
    chk_state("R8 split stop", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule